// File: doc/BRIEF.md
# Two-Channel PWM Output Qualifier with Continuous Force

This block turns the events of a shared time base into two PWM output levels, channel A and channel B. On every time-base tick it looks at three events: the counter reaching zero, the counter reaching its period, and the counter matching the channel's own compare value while counting up. Each channel has an action word that gives every event a 2-bit code. The code tells the output to stay as it is, go low, go high or toggle.

On top of the event logic sits a continuous force. Software writes a requested force level for each channel into a shadow field. A reload selector decides when that request is copied into the active force register: at zero, at period, at either of them, or on the next tick. While a channel's active force is on, the force alone decides that channel's level. The time-base counter and the register access path live outside the block. Their values arrive here as plain inputs.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset both outputs are low and the active force of both channels is disabled. With all action codes 00, the outputs then stay low whatever events arrive.
- R2: On a tick, the action code of the selected event sets the output: 00 leaves it unchanged, 01 drives it low, 10 drives it high, 11 inverts it.
- R3: Action word fields: zero event at bits 1:0, period event at bits 3:2. Channel A takes its compare code from bits 5:4 of its word and matches `cmp_a`. Channel B takes its compare code from bits 9:8 of its word and matches `cmp_b`. Both channels see the same zero and period events.
- R4: A compare match happens only when `cnt` equals the compare value while `cnt_up` is 1. With `cnt_up` at 0 an equal value causes no action.
- R5: When several events occur on the same tick, the compare code wins over the period code, and the period code wins over the zero code. A code of 00 does not mask a lower-priority event.
- R6: The outputs change only on clock edges where `tick` is 1.
- R7: Force request fields: channel A at `frc_req[1:0]`, channel B at `frc_req[3:2]`. Code 01 holds the output low, 10 holds it high, 00 and 11 disable the force. An active force overrides every event action on that channel.
- R8: The force request is copied into the active force on a tick that meets the reload selection `rld_sel`: 00 zero event, 01 period event, 10 zero or period event, 11 every tick. On that same tick the newly loaded value already governs the output. Until the copy happens, the previous active force stays in effect.
- R9: With `rld_sel` = 11, a changed force request decides the output from the very next tick.
- R10: After a force is released, event actions continue from the level the force left behind. For example, a toggle inverts the forced level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick enable |
| cnt | input | CNT_W | Time-base counter value |
| cnt_up | input | 1 | 1 while the counter counts up |
| zero_evt | input | 1 | Counter-at-zero event |
| prd_evt | input | 1 | Counter-at-period event |
| cmp_a | input | CNT_W | Compare value for channel A |
| cmp_b | input | CNT_W | Compare value for channel B |
| act_a | input | 10 | Action word of channel A |
| act_b | input | 10 | Action word of channel B |
| frc_req | input | 4 | Requested (shadow) continuous force codes |
| rld_sel | input | 2 | Force reload point selection |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
The assertions check, on every cycle, the properties that hold one cycle later at the ports and force register:
- a forced channel sits at its forced level;
- nothing moves without a tick;
- a down-counting match alone leaves the output unchanged;
- a compare code of 01 on an up-count match drives the output low;
- immediate reload copies the request, and a zero-only reload holds the active force between zero events.

Only the bench scenarios can show the effects that span several ticks or several fields at once:
- priority when events coincide;
- the toggle chain after a force is released;
- each reload point deferring a request until its event;
- the field placement that separates channel A from channel B.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int ACT_W = 10;
  localparam int FRC_W = 4;

  typedef enum logic [1:0] {
    AQ_NONE   = 2'b00,
    AQ_LOW    = 2'b01,
    AQ_HIGH   = 2'b10,
    AQ_TOGGLE = 2'b11
  } aq_code_e;

  typedef enum logic [1:0] {
    RLD_ZERO = 2'b00,
    RLD_PRD  = 2'b01,
    RLD_BOTH = 2'b10,
    RLD_IMM  = 2'b11
  } rld_mode_e;

  // highest-priority occurring event with a non-zero code
  function automatic logic [1:0] pick_code(input logic z, input logic p, input logic c,
                                           input logic [1:0] cz, input logic [1:0] cp,
                                           input logic [1:0] cc);
    if (c && cc != AQ_NONE) return cc;
    else if (p && cp != AQ_NONE) return cp;
    else if (z && cz != AQ_NONE) return cz;
    else return AQ_NONE;
  endfunction

  function automatic logic apply_code(input logic [1:0] code, input logic cur);
    case (code)
      AQ_LOW:    return 1'b0;
      AQ_HIGH:   return 1'b1;
      AQ_TOGGLE: return ~cur;
      default:   return cur;
    endcase
  endfunction

  function automatic logic force_on(input logic [1:0] f);
    return (f == 2'b01) || (f == 2'b10);
  endfunction

  function automatic logic reload_hit(input logic [1:0] mode, input logic z, input logic p);
    case (mode)
      RLD_ZERO: return z;
      RLD_PRD:  return p;
      RLD_BOTH: return z | p;
      default:  return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/pwm_aq_force.sv
module pwm_aq_force
  import pwm_aq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             zero_evt,
  input  logic             prd_evt,
  input  logic [FRC_W-1:0] frc_req,
  input  logic [1:0]       rld_sel,
  output logic [FRC_W-1:0] frc_eff
);
  logic [FRC_W-1:0] frc_act;
  logic             load_now;

  assign load_now = tick && reload_hit(rld_sel, zero_evt, prd_evt);
  assign frc_eff  = load_now ? frc_req : frc_act;

  always_ff @(posedge clk) begin
    if (!rst_n)        frc_act <= '0;
    else if (load_now) frc_act <= frc_req;
  end

  // R9: immediate reload copies the request on every tick
  p_imm_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rld_sel == 2'b11) |=> (frc_act == $past(frc_req)));

  // R8: zero-only reload holds the active force between zero events
  p_zero_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_sel == 2'b00 && !(tick && zero_evt)) |=> $stable(frc_act));
endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_up,
  input  logic             zero_evt,
  input  logic             prd_evt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [1:0]       code_zro,
  input  logic [1:0]       code_prd,
  input  logic [1:0]       code_cmp,
  input  logic [1:0]       frc_code,
  output logic             pwm
);
  logic       cmp_hit;
  logic [1:0] sel_code;
  logic       frc_active;
  logic       out_q;
  logic       out_d;

  assign cmp_hit    = cnt_up && (cnt == cmp);
  assign sel_code   = pick_code(zero_evt, prd_evt, cmp_hit, code_zro, code_prd, code_cmp);
  assign frc_active = force_on(frc_code);
  assign out_d      = frc_active ? frc_code[1] : apply_code(sel_code, out_q);
  assign pwm        = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    out_q <= 1'b0;
    else if (tick) out_q <= out_d;
  end

  p_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pwm));

  p_force_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_code == 2'b01) |=> !pwm);

  p_force_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frc_code == 2'b10) |=> pwm);

  p_down_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_up && cnt == cmp && !zero_evt && !prd_evt && !frc_active) |=> $stable(pwm));

  p_cmp_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cmp_hit && code_cmp == 2'b01 && !frc_active) |=> !pwm);
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_up,
  input  logic             zero_evt,
  input  logic             prd_evt,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [ACT_W-1:0] act_a,
  input  logic [ACT_W-1:0] act_b,
  input  logic [FRC_W-1:0] frc_req,
  input  logic [1:0]       rld_sel,
  output logic             pwm_a,
  output logic             pwm_b
);
  localparam int NUM_CH = 2;

  logic [FRC_W-1:0] frc_eff;
  logic [CNT_W-1:0] cmp_v  [NUM_CH];
  logic [ACT_W-1:0] act_v  [NUM_CH];
  logic [1:0]       ccmp_v [NUM_CH];
  logic             pwm_v  [NUM_CH];
  logic             unused_bits;

  assign cmp_v[0]  = cmp_a;
  assign cmp_v[1]  = cmp_b;
  assign act_v[0]  = act_a;
  assign act_v[1]  = act_b;
  // R3: channel A compare code at bits 5:4, channel B at bits 9:8
  assign ccmp_v[0] = act_a[5:4];
  assign ccmp_v[1] = act_b[9:8];
  assign unused_bits = ^{act_a[9:6], act_b[7:4]};

  pwm_aq_force u_force (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .zero_evt (zero_evt),
    .prd_evt  (prd_evt),
    .frc_req  (frc_req),
    .rld_sel  (rld_sel),
    .frc_eff  (frc_eff)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_aq_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .cnt      (cnt),
      .cnt_up   (cnt_up),
      .zero_evt (zero_evt),
      .prd_evt  (prd_evt),
      .cmp      (cmp_v[g]),
      .code_zro (act_v[g][1:0]),
      .code_prd (act_v[g][3:2]),
      .code_cmp (ccmp_v[g]),
      .frc_code (frc_eff[2*g +: 2]),
      .pwm      (pwm_v[g])
    );
  end

  assign pwm_a = pwm_v[0];
  assign pwm_b = pwm_v[1];

  // R1: out of reset, with nothing forcing and no actions, outputs stay low
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |=> (!pwm_a && !pwm_b));
endmodule

// File: tb/pwm_action_qual_tb.sv
module pwm_action_qual_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic             cnt_up = 1'b1;
  logic             zero_evt = 1'b0;
  logic             prd_evt = 1'b0;
  logic [CNT_W-1:0] cmp_a = '0;
  logic [CNT_W-1:0] cmp_b = '0;
  logic [9:0]       act_a = '0;
  logic [9:0]       act_b = '0;
  logic [3:0]       frc_req = '0;
  logic [1:0]       rld_sel = '0;
  logic             pwm_a;
  logic             pwm_b;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  logic       ma = 1'b0, mb = 1'b0;
  logic [3:0] mfrc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_action_qual #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_up(cnt_up),
    .zero_evt(zero_evt), .prd_evt(prd_evt), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .act_a(act_a), .act_b(act_b), .frc_req(frc_req), .rld_sel(rld_sel),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  // resolve code: lower priorities written first, overwritten by higher ones
  function automatic logic [1:0] m_code(logic z, logic p, logic hit, logic [9:0] w, int lsb);
    logic [1:0] r = 2'b00;
    if (z && w[1:0] != 2'b00) r = w[1:0];
    if (p && w[3:2] != 2'b00) r = w[3:2];
    if (hit && w[lsb +: 2] != 2'b00) r = w[lsb +: 2];
    return r;
  endfunction

  function automatic logic m_level(logic cur, logic [1:0] code, logic [1:0] f);
    if (f == 2'b01) return 1'b0;
    if (f == 2'b10) return 1'b1;
    case (code)
      2'b01: return 1'b0;
      2'b10: return 1'b1;
      2'b11: return !cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic m_load(logic [1:0] mode, logic z, logic p);
    if (mode == 2'b11) return 1'b1;
    if (mode == 2'b10) return z || p;
    if (mode == 2'b01) return p;
    return z;
  endfunction

  task automatic check(string tag);
    checks++;
    if (pwm_a !== ma || pwm_b !== mb) begin
      errors++;
      $display("FAIL %s: pwm_a/pwm_b actual %b%b expected %b%b", tag, pwm_a, pwm_b, ma, mb);
    end
  endtask

  task automatic step(logic tk, logic [CNT_W-1:0] c, logic up, logic z, logic p, string tag);
    logic [3:0] f;
    tick = tk; cnt = c; cnt_up = up; zero_evt = z; prd_evt = p;
    if (tk) begin
      f = m_load(rld_sel, z, p) ? frc_req : mfrc;
      mfrc = f;
      ma = m_level(ma, m_code(z, p, up && c == cmp_a, act_a, 4), f[1:0]);
      mb = m_level(mb, m_code(z, p, up && c == cmp_b, act_b, 8), f[3:2]);
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset outputs low");
    step(1, 0, 1, 1, 1, "R1 no actions after reset");
    step(1, 0, 1, 0, 0, "R1 force disabled after reset");

    // normal polarity: high on zero/period, low on compare-up
    cmp_a = 3; cmp_b = 5;
    act_a = 10'h01A; act_b = 10'h10A;
    step(1, 0, 1, 1, 0, "R2 zero drives high");
    step(1, 3, 1, 0, 0, "R3 channel A compare bits 5:4");
    step(1, 5, 1, 0, 0, "R3 channel B compare bits 9:8");
    step(1, 9, 1, 0, 1, "R3 shared period event");
    step(1, 3, 0, 0, 0, "R4 down-count equal no match");
    step(1, 5, 0, 0, 0, "R4 down-count channel B no match");
    step(0, 3, 1, 0, 0, "R6 no tick no change");
    step(0, 0, 1, 1, 1, "R6 no tick ignores events");
    // inverted polarity
    act_a = 10'h025; act_b = 10'h205;
    step(1, 0, 1, 1, 0, "R2 inverted zero low");
    step(1, 3, 1, 0, 0, "R2 inverted compare high");
    // priority
    act_a = 10'h01A; act_b = 10'h00A;
    step(1, 3, 1, 1, 1, "R5 compare beats period and zero");
    act_a = 10'h006;
    step(1, 3, 1, 1, 1, "R5 period beats zero, 00 compare no mask");
    act_a = 10'h002;
    step(1, 3, 1, 1, 1, "R5 zero applies when higher codes 00");
    // toggle
    act_a = 10'h003; act_b = 10'h003;
    step(1, 0, 1, 1, 0, "R2 toggle once");
    step(1, 0, 1, 1, 0, "R2 toggle twice");

    // immediate force
    rld_sel = 2'b11; frc_req = 4'b0110;
    step(1, 0, 1, 1, 0, "R9 immediate force next tick");
    step(1, 0, 1, 1, 0, "R7 force overrides toggle");
    frc_req = 4'b1001;
    step(1, 7, 1, 0, 0, "R7 swap forced levels");
    frc_req = 4'b1100;
    step(1, 7, 1, 0, 0, "R7 codes 00/11 disable force");
    step(1, 0, 1, 1, 0, "R10 toggle from forced level");

    // deferred reload modes
    act_a = 10'h000; act_b = 10'h000;
    rld_sel = 2'b00; frc_req = 4'b1010;
    step(1, 4, 1, 0, 1, "R8 zero mode ignores period");
    step(1, 0, 1, 1, 0, "R8 zero mode loads on zero");
    rld_sel = 2'b01; frc_req = 4'b0101;
    step(1, 0, 1, 1, 0, "R8 period mode ignores zero");
    step(1, 0, 1, 0, 1, "R8 period mode loads on period");
    rld_sel = 2'b10; frc_req = 4'b1010;
    step(1, 2, 1, 0, 0, "R8 either mode waits");
    step(0, 0, 1, 1, 0, "R8 no load without tick");
    step(1, 0, 1, 1, 0, "R8 either mode loads on zero");
    frc_req = 4'b0000;
    step(1, 2, 1, 0, 1, "R8 either mode loads on period");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      if (i % 16 == 0) begin
        act_a = 10'($urandom); act_b = 10'($urandom);
        cmp_a = CNT_W'($urandom % 8); cmp_b = CNT_W'($urandom % 8);
        rld_sel = 2'($urandom);
        if ($urandom % 2 == 0) frc_req = 4'($urandom);
      end
      begin
        logic [CNT_W-1:0] c = CNT_W'($urandom % 8);
        step(($urandom % 4) != 0, c, 1'($urandom), (c == 0) || ($urandom % 8 == 0),
             ($urandom % 5 == 0), "R2 R5 R7 R8 random");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule